// File: doc/BRIEF.md
# Programmable Interval Timer with Limit

This block is an up-counter with a software-set ceiling. A small register bus gives software three registers: the live count, a limit value and a control word. While the control word's run bit is set, the count goes up by one on every clock. When the count equals the limit it goes back to zero. If interrupt-enable is set when that happens, the block raises a pending flag and drives a level interrupt. The flag stays set until software writes the control register. Any data written there acknowledges the interrupt.

One instance can serve as a free-running time base: set the limit to all ones and clear interrupt-enable. Another instance can serve as an event source. Software writes the interval into the limit, clears the count and sets run. For periodic ticks it sets interrupt-enable again on every acknowledge. For a single event it clears interrupt-enable on the acknowledge and leaves the counter running. Reset is synchronous and active low.

Top module: `interval_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the limit and all control state clear. The three registers then read zero and `irq` is low.
- R2: The bus addresses are count = 0, limit = 1, control = 2. While control bit 1 (run) is 1, the count rises by one per clock. While run is 0 the count holds.
- R3: When the count equals the limit on a clock where run is 1 and no count write occurs, the next count is zero.
- R4: If control bit 0 (interrupt-enable) is 1 on that limit-match clock, the pending flag (read at control bit 3) sets on that edge. It then stays set until a control write.
- R5: A limit match while interrupt-enable is 0 does not set the pending flag.
- R6: A write to the control register clears the pending flag whatever data is written. The one exception is a limit match with interrupt-enable 1 on the same clock; then the flag sets.
- R7: A bus write to the count register loads the written value and takes priority over the increment and the wrap on the same clock.
- R8: `irq` is high exactly when the pending flag is 1 and interrupt-enable is 1.
- R9: The control register reads bit 0 interrupt-enable, bit 1 run and bit 3 pending, with every other bit zero. Address 3 reads zero, and `rd_data` shows the addressed register without delay.
- R10: With the limit at all ones and interrupt-enable 0, the count wraps from all ones to zero and never raises the interrupt.
- R11: After an acknowledge that writes run = 1 and interrupt-enable = 0, the counter keeps running through later matches and no further interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register select: 0 count, 1 limit, 2 control |
| bus_wdata | input | W | Write data |
| rd_data | output | W | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt: pending AND interrupt-enable |

## Verification
- **Count register faults.** A wrong increment, hold or wrap decision shows up on the count readback at the very next clock. The bench reads the count right after each critical edge: the halted hold, the first step after run is set, the match edge and a count write that collides with counting.
- **Pending flag faults.** A pending flag that sets, holds or clears at the wrong time is visible the same cycle. It shows at control bit 3 and at `irq`.
- **Hidden flag state.** The collision in which an acknowledge that clears interrupt-enable meets a match is checked on its own. In that case the flag is set while `irq` stays low, so only the readback shows it.

// File: rtl/tmr_pkg.sv
// Package: shared register addresses and control bit positions for the
// interval timer. Assumes a two-bit register address space.
package tmr_pkg;
    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_LIMIT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_NONE  = 2'd3
    } tmr_reg_e;

    localparam int CTL_IE_BIT   = 0;
    localparam int CTL_RUN_BIT  = 1;
    localparam int CTL_PEND_BIT = 3;
    localparam int ADDR_W       = 2;
endpackage

// File: rtl/tmr_regs.sv
// Register file: decodes bus writes, holds the limit and control bits and
// muxes the read data. Assumes W >= 4 so that every control bit fits.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [W-1:0]        wdata,
    input  logic [W-1:0]        cnt,
    input  logic                pend,
    output logic [W-1:0]        lim,
    output logic                ie,
    output logic                run,
    output logic                cnt_wr,
    output logic                ctl_wr,
    output logic [W-1:0]        rdata
);
    tmr_reg_e sel;
    logic     lim_wr;

    // Purpose: decode the target register of a bus write.
    always_comb begin
        sel    = tmr_reg_e'(addr);
        cnt_wr = wr_en && (sel == REG_COUNT);
        lim_wr = wr_en && (sel == REG_LIMIT);
        ctl_wr = wr_en && (sel == REG_CTRL);
    end

    // Purpose: hold the limit register.
    always_ff @(posedge clk) begin
        if (!rst_n)      lim <= '0;
        else if (lim_wr) lim <= wdata;
    end

    // Purpose: hold the interrupt-enable and run bits of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie  <= 1'b0;
            run <= 1'b0;
        end else if (ctl_wr) begin
            ie  <= wdata[CTL_IE_BIT];
            run <= wdata[CTL_RUN_BIT];
        end
    end

    // Purpose: select the read data for the addressed register.
    always_comb begin
        rdata = '0;
        case (sel)
            REG_COUNT: rdata = cnt;
            REG_LIMIT: rdata = lim;
            REG_CTRL: begin
                rdata[CTL_IE_BIT]   = ie;
                rdata[CTL_RUN_BIT]  = run;
                rdata[CTL_PEND_BIT] = pend;
            end
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_counter.sv
// Counter core: loads on a bus write, otherwise steps while running and
// wraps to zero on a limit match. Flags the match event for the irq logic.
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         match
);
    // Purpose: a counting clock whose count equals the limit.
    always_comb match = run && !cnt_wr && (cnt == lim);

    // Purpose: update the count with the bus write taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= wdata;
        else if (match)  cnt <= '0;
        else if (run)    cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_irq.sv
// Interrupt logic: the pending flag sets on an enabled match and clears on
// any control write. A set on the same clock wins so that no event is lost.
module tmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic ie,
    input  logic ack,
    output logic pend,
    output logic irq
);
    // Purpose: track the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend <= 1'b0;
        else if (match && ie)  pend <= 1'b1;
        else if (ack)          pend <= 1'b0;
    end

    // Purpose: gate the output level with interrupt-enable.
    always_comb irq = pend && ie;
endmodule

// File: rtl/interval_timer.sv
// Top: an interval timer with count, limit and control registers on a
// simple write-strobe bus with combinational read data.
module interval_timer
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      rd_data,
    output logic              irq
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] lim_q;
    logic         ie_q;
    logic         run_q;
    logic         pend_q;
    logic         cnt_wr;
    logic         ctl_wr;
    logic         match;

    tmr_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt_q), .pend(pend_q), .lim(lim_q),
        .ie(ie_q), .run(run_q), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr),
        .rdata(rd_data)
    );

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(bus_wdata),
        .run(run_q), .lim(lim_q), .cnt(cnt_q), .match(match)
    );

    tmr_irq u_irq (
        .clk(clk), .rst_n(rst_n), .match(match), .ie(ie_q),
        .ack(ctl_wr), .pend(pend_q), .irq(irq)
    );
endmodule

// File: rtl/tmr_checker.sv
// Checker: temporal properties of the timer. It recomputes the bus decode
// from the ports and reads the state registers through the bind.
module tmr_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] cnt,
    input logic [W-1:0] lim,
    input logic         ie,
    input logic         run,
    input logic         pend,
    input logic         irq
);
    logic wc, wk, hit;
    always_comb begin
        wc  = wr_en && (addr == 2'd0);
        wk  = wr_en && (addr == 2'd2);
        hit = run && !wc && (cnt == lim);
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wc) |=> $stable(cnt));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wc && cnt != lim) |=> (cnt == $past(cnt) + 1'b1));
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt == '0));
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ie) |=> pend);
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && !(hit && ie)) |=> !pend);
    p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wk && !(hit && ie)) |=> !pend);
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wc |=> (cnt == $past(wdata)));
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && ie));
endmodule

bind interval_timer tmr_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt_q), .lim(lim_q), .ie(ie_q),
    .run(run_q), .pend(pend_q), .irq(irq)
);

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    localparam int PERIOD = 10;
    localparam int W = 32;
    localparam int NV = 36;
    // entry: {op[1:0], addr[1:0], req[3:0], data[31:0], exp[31:0]}
    // op 0 write, 1 read-and-compare, 2 idle data cycles
    localparam logic [71:0] VEC [NV] = '{
        {2'd1, 2'd0, 4'd1, 32'd0, 32'd0},         // R1 count
        {2'd1, 2'd1, 4'd1, 32'd0, 32'd0},         // R1 limit
        {2'd1, 2'd2, 4'd1, 32'd0, 32'd0},         // R1 control
        {2'd0, 2'd1, 4'd0, 32'd5, 32'd0},
        {2'd0, 2'd0, 4'd0, 32'd2, 32'd0},
        {2'd1, 2'd0, 4'd7, 32'd0, 32'd2},         // R7 load
        {2'd2, 2'd0, 4'd0, 32'd3, 32'd0},
        {2'd1, 2'd0, 4'd2, 32'd0, 32'd2},         // R2 halted hold
        {2'd0, 2'd2, 4'd0, 32'd2, 32'd0},
        {2'd1, 2'd0, 4'd2, 32'd0, 32'd2},
        {2'd2, 2'd0, 4'd0, 32'd2, 32'd0},
        {2'd1, 2'd0, 4'd2, 32'd0, 32'd4},         // R2 step
        {2'd2, 2'd0, 4'd0, 32'd1, 32'd0},
        {2'd1, 2'd0, 4'd2, 32'd0, 32'd5},
        {2'd1, 2'd2, 4'd9, 32'd0, 32'd2},         // R9 control bits
        {2'd2, 2'd0, 4'd0, 32'd1, 32'd0},
        {2'd1, 2'd0, 4'd3, 32'd0, 32'd0},         // R3 wrap
        {2'd1, 2'd2, 4'd5, 32'd0, 32'd2},         // R5 no pending
        {2'd0, 2'd2, 4'd0, 32'd3, 32'd0},
        {2'd1, 2'd0, 4'd2, 32'd0, 32'd1},
        {2'd2, 2'd0, 4'd0, 32'd4, 32'd0},
        {2'd1, 2'd0, 4'd3, 32'd0, 32'd5},
        {2'd2, 2'd0, 4'd0, 32'd1, 32'd0},
        {2'd1, 2'd2, 4'd4, 32'd0, 32'hB},         // R4 pending set
        {2'd1, 2'd0, 4'd3, 32'd0, 32'd0},
        {2'd2, 2'd0, 4'd0, 32'd3, 32'd0},
        {2'd1, 2'd2, 4'd4, 32'd0, 32'hB},         // R4 pending held
        {2'd0, 2'd2, 4'd0, 32'd3, 32'd0},
        {2'd1, 2'd2, 4'd6, 32'd0, 32'd3},         // R6 ack
        {2'd1, 2'd0, 4'd2, 32'd0, 32'd4},
        {2'd0, 2'd0, 4'd0, 32'd1, 32'd0},
        {2'd1, 2'd0, 4'd7, 32'd0, 32'd1},         // R7 write beats increment
        {2'd1, 2'd3, 4'd9, 32'd0, 32'd0},         // R9 unused address
        {2'd0, 2'd2, 4'd0, 32'hFFFF_FFF3, 32'd0},
        {2'd1, 2'd2, 4'd9, 32'd0, 32'd3},         // R9 other bits zero
        {2'd1, 2'd1, 4'd9, 32'd0, 32'd5}          // R9 limit readback
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] rd_data;
    logic         irq;
    int           checks = 0;
    int           fails = 0;
    bit           done = 1'b0;

    interval_timer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .irq(irq)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input string req, input logic [W-1:0] exp);
        bus_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int i = 0; i < NV; i++) begin
            logic [71:0] v;
            v = VEC[i];
            case (v[71:70])
                2'd0: wr(v[69:68], v[63:32]);
                2'd1: rd(v[69:68], $sformatf("R%0d vec%0d", v[67:64], i), v[31:0]);
                default: idle(int'(v[63:32]));
            endcase
        end
        // count 2, limit 5, ie=1, run=1
        idle(4);
        chk("R8 irq high", {31'd0, irq}, 32'd1);
        wr(2'd2, 32'h0);
        chk("R6 ack any data irq", {31'd0, irq}, 32'd0);
        rd(2'd2, "R6 ack any data ctrl", 32'd0);
        // match coinciding with an acknowledge that clears ie
        wr(2'd0, 32'd4);
        wr(2'd2, 32'd3);
        idle(1);
        wr(2'd2, 32'd2);
        rd(2'd2, "R6 set wins over ack", 32'hA);
        chk("R8 pending without ie", {31'd0, irq}, 32'd0);
        // one-shot: acknowledge with ie clear, counter runs on
        wr(2'd2, 32'd2);
        idle(5);
        rd(2'd0, "R11 wrapped", 32'd0);
        rd(2'd2, "R11 no new pending", 32'd2);
        chk("R11 irq", {31'd0, irq}, 32'd0);
        idle(2);
        rd(2'd0, "R11 still running", 32'd2);
        // free-running wrap at all ones
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'hFFFF_FFFD);
        idle(2);
        rd(2'd0, "R10 top", 32'hFFFF_FFFF);
        idle(1);
        rd(2'd0, "R10 wrap", 32'd0);
        rd(2'd2, "R10 no pending", 32'd2);
        chk("R10 irq", {31'd0, irq}, 32'd0);
        // reset mid-run
        rst_n = 1'b0;
        idle(1);
        rst_n = 1'b1;
        rd(2'd0, "R1 count after reset", 32'd0);
        rd(2'd1, "R1 limit after reset", 32'd0);
        rd(2'd2, "R1 ctrl after reset", 32'd0);
        idle(2);
        rd(2'd0, "R2 halted after reset", 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule